// File: doc/BRIEF.md
# Text Command Register Access Parser

This block sits between a serial receiver and a serial transmitter that both work on whole bytes. It reads a stream of ASCII characters and interprets two short text commands. One writes a small bank of 8-bit configuration registers. The other reads one of them back. The register contents are driven in parallel onto an output bus, where a time-window comparison circuit can use them as window limits.

The write command is `WR`, a register index and a hex value. The read command is `RD` and a register index. Fields are separated by spaces, and a line ends at carriage return or line feed. A read answers with the register value as two uppercase hex digits, then CR and LF. A line that does not fit the grammar is thrown away in full, and no register changes. Both byte streams use valid/ready handshakes. While a reply is still being sent, the receive side is held off.

Top module: `regcmd_parser`

## Requirements
- R1: After reset, every register is 0x00, `tx_valid_o` is 0 and `rx_ready_o` is 1.
- R2: A line `WR`, spaces, index digit i (ASCII '0'..'3'), spaces, hex value v, optional spaces, then CR (0x0D) or LF (0x0A), sets register i to v. The new value is visible in the cycle after the terminator is accepted. The other registers keep their values.
- R3: A separator is one or more spaces (0x20). Spaces before the terminator are allowed. Spaces and terminators received while no command is in progress are ignored.
- R4: Hex digits 0-9, A-F and a-f are accepted. The value has one or two digits, and a single digit gives a value below 0x10.
- R5: A line `RD`, spaces, index digit i, optional spaces, then a terminator, sends exactly four bytes: the high nibble of register i as an uppercase ASCII hex digit, then the low nibble, then 0x0D, then 0x0A. No other input makes the block transmit.
- R6: A reply byte stays stable on `tx_data_o` while `tx_valid_o` is high and `tx_ready_i` is low. `rx_ready_o` is low for as long as a reply is pending.
- R7: A line is malformed if it has an index other than '0'..'3', a non-hex value character, more than two value digits, a missing space or field, or unknown command letters. A malformed line changes no register and sends nothing. Parsing starts again after the next terminator.
- R8: Register i appears on `regs_o[8*i+7 : 8*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data_i | input | 8 | Received ASCII character |
| rx_valid_i | input | 1 | Received character is present |
| rx_ready_o | output | 1 | Parser can take a character |
| tx_data_o | output | 8 | Reply character |
| tx_valid_o | output | 1 | Reply character is present |
| tx_ready_i | input | 1 | Transmitter takes the reply character |
| regs_o | output | 32 | All registers, register i in byte lane i |

## Verification
The assertions check four things on every cycle. A reply byte holds steady under back-pressure. Receiving is blocked during a reply. Registers move only in the cycle after a terminator was taken. A reply only starts after a terminator and only carries hex digits, CR or LF. The bench scenarios cover what the assertions cannot. They sweep every value into every register, with mixed case, one- and two-digit values, varied spacing and both terminators. They read each register back and compare the exact reply bytes. They feed a set of malformed lines and confirm that these change nothing and that the parser recovers at the next line.

// File: rtl/regcmd_pkg.sv
package regcmd_pkg;

    localparam logic [7:0] CH_SP = 8'h20;
    localparam logic [7:0] CH_CR = 8'h0D;
    localparam logic [7:0] CH_LF = 8'h0A;
    localparam logic [7:0] CH_W  = 8'h57;
    localparam logic [7:0] CH_R  = 8'h52;
    localparam logic [7:0] CH_D  = 8'h44;

    typedef enum logic [3:0] {
        P_IDLE,
        P_OPW,
        P_OPR,
        P_SEP,
        P_IDX,
        P_AFTIDX,
        P_VAL,
        P_VALN,
        P_TAIL,
        P_SKIP
    } pstate_e;

    typedef struct packed {
        logic       sp;
        logic       term;
        logic       hex;
        logic [3:0] nib;
        logic       dig;
        logic [3:0] dec;
    } chcls_t;

    function automatic logic [7:0] nib2asc(input logic [3:0] n);
        if (n < 4'd10) return 8'h30 + {4'd0, n};
        return 8'h37 + {4'd0, n};
    endfunction

endpackage

// File: rtl/char_class.sv
module char_class
    import regcmd_pkg::*;
(
    input  logic [7:0] ch_i,
    output chcls_t     cls_o
);
    always_comb begin
        cls_o      = '0;
        cls_o.sp   = (ch_i == CH_SP);
        cls_o.term = (ch_i == CH_CR) || (ch_i == CH_LF);
        cls_o.dec  = ch_i[3:0];
        if (ch_i >= 8'h30 && ch_i <= 8'h39) begin
            cls_o.dig = 1'b1;
            cls_o.hex = 1'b1;
            cls_o.nib = ch_i[3:0];
        end else if (ch_i >= 8'h41 && ch_i <= 8'h46) begin
            cls_o.hex = 1'b1;
            cls_o.nib = ch_i[3:0] + 4'd9;
        end else if (ch_i >= 8'h61 && ch_i <= 8'h66) begin
            cls_o.hex = 1'b1;
            cls_o.nib = ch_i[3:0] + 4'd9;
        end
    end
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
    parameter int NREG = 4,
    parameter int DW   = 8,
    parameter int IW   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [IW-1:0]      waddr_i,
    input  logic [DW-1:0]      wdata_i,
    input  logic [IW-1:0]      raddr_i,
    output logic [DW-1:0]      rdata_o,
    output logic [NREG*DW-1:0] flat_o
);
    logic [DW-1:0] regs_d [NREG];
    logic [DW-1:0] regs_q [NREG];

    always_comb begin
        regs_d = regs_q;
        if (we_i) regs_d[waddr_i] = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NREG; k++) regs_q[k] <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rdata_o = regs_q[raddr_i];

    for (genvar g = 0; g < NREG; g++) begin : g_lane
        assign flat_o[g*DW +: DW] = regs_q[g];
    end
endmodule

// File: rtl/hex_reply_tx.sv
module hex_reply_tx
    import regcmd_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [DW-1:0] value_i,
    input  logic          tx_ready_i,
    output logic          tx_valid_o,
    output logic [7:0]    tx_data_o,
    output logic          busy_o
);
    localparam int HEXD  = DW / 4;
    localparam int NBYTE = HEXD + 2;
    localparam int PW    = $clog2(NBYTE);

    typedef struct packed {
        logic          busy;
        logic [PW-1:0] pos;
        logic [DW-1:0] val;
    } tx_st_t;

    tx_st_t tx_d, tx_q;

    always_comb begin
        tx_d = tx_q;
        if (load_i) begin
            tx_d.busy = 1'b1;
            tx_d.pos  = '0;
            tx_d.val  = value_i;
        end else if (tx_q.busy && tx_ready_i) begin
            if (int'(tx_q.pos) == NBYTE - 1) begin
                tx_d.busy = 1'b0;
                tx_d.pos  = '0;
            end else begin
                tx_d.pos = tx_q.pos + 1'b1;
                tx_d.val = tx_q.val << 4;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    always_comb begin
        if (int'(tx_q.pos) < HEXD)       tx_data_o = nib2asc(tx_q.val[DW-1 -: 4]);
        else if (int'(tx_q.pos) == HEXD) tx_data_o = CH_CR;
        else                             tx_data_o = CH_LF;
    end

    assign tx_valid_o = tx_q.busy;
    assign busy_o     = tx_q.busy;
endmodule

// File: rtl/regcmd_parser.sv
module regcmd_parser
    import regcmd_pkg::*;
#(
    parameter int NREG = 4,
    parameter int DW   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         rx_data_i,
    input  logic               rx_valid_i,
    output logic               rx_ready_o,
    output logic [7:0]         tx_data_o,
    output logic               tx_valid_o,
    input  logic               tx_ready_i,
    output logic [NREG*DW-1:0] regs_o
);
    localparam int IW   = (NREG > 1) ? $clog2(NREG) : 1;
    localparam int HEXD = DW / 4;
    localparam int NDW  = $clog2(HEXD + 1);

    typedef struct packed {
        pstate_e        state;
        logic           wr;
        logic [IW-1:0]  idx;
        logic [DW-1:0]  val;
        logic [NDW-1:0] ndig;
    } ps_t;

    ps_t           ps_d, ps_q;
    chcls_t        cls;
    logic          rx_fire, wr_en, rd_go, tx_busy;
    logic [DW-1:0] rdata;

    char_class u_cls (.ch_i(rx_data_i), .cls_o(cls));

    assign rx_ready_o = !tx_busy;
    assign rx_fire    = rx_valid_i && rx_ready_o;

    always_comb begin
        ps_d  = ps_q;
        wr_en = 1'b0;
        rd_go = 1'b0;
        if (rx_fire) begin
            case (ps_q.state)
                P_IDLE: begin
                    if (cls.sp || cls.term) ps_d.state = P_IDLE;
                    else if (rx_data_i == CH_W) begin
                        ps_d.state = P_OPW;
                        ps_d.wr    = 1'b1;
                    end else if (rx_data_i == CH_R) begin
                        ps_d.state = P_OPR;
                        ps_d.wr    = 1'b0;
                    end else ps_d.state = P_SKIP;
                end
                P_OPW: begin
                    if (rx_data_i == CH_R) ps_d.state = P_SEP;
                    else if (cls.term)     ps_d.state = P_IDLE;
                    else                   ps_d.state = P_SKIP;
                end
                P_OPR: begin
                    if (rx_data_i == CH_D) ps_d.state = P_SEP;
                    else if (cls.term)     ps_d.state = P_IDLE;
                    else                   ps_d.state = P_SKIP;
                end
                P_SEP: begin
                    if (cls.sp)        ps_d.state = P_IDX;
                    else if (cls.term) ps_d.state = P_IDLE;
                    else               ps_d.state = P_SKIP;
                end
                P_IDX: begin
                    if (cls.sp) ps_d.state = P_IDX;
                    else if (cls.dig && int'(cls.dec) < NREG) begin
                        ps_d.idx   = cls.dec[IW-1:0];
                        ps_d.state = P_AFTIDX;
                    end else if (cls.term) ps_d.state = P_IDLE;
                    else ps_d.state = P_SKIP;
                end
                P_AFTIDX: begin
                    if (cls.term) begin
                        rd_go      = !ps_q.wr;
                        ps_d.state = P_IDLE;
                    end else if (cls.sp) ps_d.state = ps_q.wr ? P_VAL : P_TAIL;
                    else ps_d.state = P_SKIP;
                end
                P_VAL: begin
                    if (cls.sp) ps_d.state = P_VAL;
                    else if (cls.hex) begin
                        ps_d.val   = {{(DW-4){1'b0}}, cls.nib};
                        ps_d.ndig  = NDW'(1);
                        ps_d.state = P_VALN;
                    end else if (cls.term) ps_d.state = P_IDLE;
                    else ps_d.state = P_SKIP;
                end
                P_VALN: begin
                    if (cls.hex && int'(ps_q.ndig) < HEXD) begin
                        ps_d.val  = {ps_q.val[DW-5:0], cls.nib};
                        ps_d.ndig = ps_q.ndig + 1'b1;
                    end else if (cls.sp) ps_d.state = P_TAIL;
                    else if (cls.term) begin
                        wr_en      = 1'b1;
                        ps_d.state = P_IDLE;
                    end else ps_d.state = P_SKIP;
                end
                P_TAIL: begin
                    if (cls.sp) ps_d.state = P_TAIL;
                    else if (cls.term) begin
                        wr_en      = ps_q.wr;
                        rd_go      = !ps_q.wr;
                        ps_d.state = P_IDLE;
                    end else ps_d.state = P_SKIP;
                end
                P_SKIP: begin
                    if (cls.term) ps_d.state = P_IDLE;
                end
                default: ps_d.state = P_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q       <= '0;
            ps_q.state <= P_IDLE;
        end else begin
            ps_q <= ps_d;
        end
    end

    cfg_regfile #(.NREG(NREG), .DW(DW), .IW(IW)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_en),
        .waddr_i (ps_q.idx),
        .wdata_i (ps_q.val),
        .raddr_i (ps_q.idx),
        .rdata_o (rdata),
        .flat_o  (regs_o)
    );

    hex_reply_tx #(.DW(DW)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (rd_go),
        .value_i    (rdata),
        .tx_ready_i (tx_ready_i),
        .tx_valid_o (tx_valid_o),
        .tx_data_o  (tx_data_o),
        .busy_o     (tx_busy)
    );
endmodule

// File: rtl/regcmd_parser_chk.sv
module regcmd_parser_chk #(
    parameter int NREG = 4,
    parameter int DW   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [7:0]         rx_data,
    input logic               rx_valid,
    input logic               rx_ready,
    input logic [7:0]         tx_data,
    input logic               tx_valid,
    input logic               tx_ready,
    input logic [NREG*DW-1:0] regs
);
    logic term_taken, tx_legal;
    assign term_taken = rx_valid && rx_ready && (rx_data == 8'h0D || rx_data == 8'h0A);
    assign tx_legal   = (tx_data >= 8'h30 && tx_data <= 8'h39) ||
                        (tx_data >= 8'h41 && tx_data <= 8'h46) ||
                        tx_data == 8'h0D || tx_data == 8'h0A;

    a_r6_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

    a_r6_rx_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !rx_ready);

    a_r7_regs_need_term: assert property (@(posedge clk) disable iff (!rst_n)
        !term_taken |=> $stable(regs));

    a_r5_tx_charset: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> tx_legal);

    a_r5_reply_after_term: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> $past(term_taken));
endmodule

bind regcmd_parser regcmd_parser_chk #(.NREG(NREG), .DW(DW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_data  (rx_data_i),
    .rx_valid (rx_valid_i),
    .rx_ready (rx_ready_o),
    .tx_data  (tx_data_o),
    .tx_valid (tx_valid_o),
    .tx_ready (tx_ready_i),
    .regs     (regs_o)
);

// File: tb/regcmd_parser_tb_top.sv
module regcmd_parser_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b1;
    logic [31:0] regs;

    int total = 0;
    int bad = 0;
    logic [7:0] mdl [4];
    logic [7:0] txq [$];

    always #2 clk = ~clk;

    regcmd_parser dut_i (
        .clk(clk), .rst_n(rst_n),
        .rx_data_i(rx_data), .rx_valid_i(rx_valid), .rx_ready_o(rx_ready),
        .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
        .regs_o(regs)
    );

    always @(negedge clk) if (tx_valid && tx_ready) txq.push_back(tx_data);

    function automatic logic [31:0] mflat();
        return {mdl[3], mdl[2], mdl[1], mdl[0]};
    endfunction

    function automatic logic [7:0] hexc(input logic [3:0] n, input bit lower);
        if (n < 10) return 8'h30 + {4'd0, n};
        return (lower ? 8'h57 : 8'h37) + {4'd0, n};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic sb(input logic [7:0] b);
        rx_data  = b;
        rx_valid = 1'b1;
        while (1) begin
            @(negedge clk);
            if (rx_ready) break;
            @(posedge clk); #1;
        end
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    task automatic sstr(input string s);
        for (int k = 0; k < s.len(); k++) sb(s[k]);
    endtask

    task automatic wait_reply(input string tag, input logic [7:0] v);
        for (int c = 0; c < 40 && txq.size() < 4; c++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(txq.size() == 4, tag, txq.size(), 4);
        if (txq.size() == 4) begin
            chk(txq[0] == hexc(v[7:4], 0), tag, txq[0], hexc(v[7:4], 0));
            chk(txq[1] == hexc(v[3:0], 0), tag, txq[1], hexc(v[3:0], 0));
            chk(txq[2] == 8'h0D, tag, txq[2], 8'h0D);
            chk(txq[3] == 8'h0A, tag, txq[3], 8'h0A);
        end
        txq.delete();
        @(posedge clk); #1;
    endtask

    task automatic do_read(input int i);
        sb("R"); sb("D"); sb(" "); sb(8'h30 + i[7:0]); sb(8'h0D);
        wait_reply("R5 read reply", mdl[i]);
    endtask

    task automatic bad_line(input string s);
        sstr(s);
        repeat (4) @(negedge clk);
        chk(regs == mflat(), "R7 malformed leaves regs", regs, mflat());
        chk(txq.size() == 0, "R7 malformed sends nothing", txq.size(), 0);
        txq.delete();
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 4; k++) mdl[k] = 8'h00;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(regs == 32'h0, "R1 regs reset", regs, 0);
        chk(tx_valid == 1'b0, "R1 tx idle", tx_valid, 0);
        chk(rx_ready == 1'b1, "R1 rx ready", rx_ready, 1);
        @(posedge clk); #1;

        // R2 R3 R4 R8: every value into every register, varied format
        for (int i = 0; i < 4; i++) begin
            for (int v = 0; v < 256; v++) begin
                bit lower = v[0];
                sb("W"); sb("R");
                repeat ((v % 3) + 1) sb(" ");
                sb(8'h30 + i[7:0]);
                repeat (((v / 3) % 2) + 1) sb(" ");
                if (v < 16 && v[0]) sb(hexc(v[3:0], lower));
                else begin
                    sb(hexc(v[7:4], lower));
                    sb(hexc(v[3:0], lower));
                end
                if (v[2]) sb(" ");
                sb(v[1] ? 8'h0A : 8'h0D);
                mdl[i] = v[7:0];
                @(negedge clk);
                chk(regs == mflat(), "R2 write sweep", regs, mflat());
                chk(regs[i*8 +: 8] == v[7:0], "R8 lane position", regs[i*8 +: 8], v);
                @(posedge clk); #1;
                if (v % 17 == 5) do_read(i);
            end
        end

        // R4 single digit, lowercase
        sstr("WR 2 c\r");
        mdl[2] = 8'h0C;
        @(negedge clk);
        chk(regs == mflat(), "R4 single digit", regs, mflat());
        @(posedge clk); #1;

        // R3 blank lines, leading and trailing spaces
        sstr("\r\n  \n WR   3   aB   \n");
        mdl[3] = 8'hAB;
        @(negedge clk);
        chk(regs == mflat(), "R3 spacing", regs, mflat());
        @(posedge clk); #1;

        sstr("WR 0 5A\r");
        mdl[0] = 8'h5A;
        sstr("WR 1 F0\n");
        mdl[1] = 8'hF0;
        for (int i = 0; i < 4; i++) do_read(i);
        sstr("RD  2   \n");
        wait_reply("R5 read with trailing spaces", mdl[2]);

        // R7 malformed lines
        bad_line("WR 4 11\r");
        bad_line("WR 1 G1\r");
        bad_line("WR 1 123\r");
        bad_line("WR1 22\r");
        bad_line("WX 1 22\r");
        bad_line("WR 1\r");
        bad_line("WR 1 \n");
        bad_line("RD 7\n");
        bad_line("RD 1 x\r");
        bad_line("RD1\r");
        bad_line("W\r");
        bad_line("wr 1 22\r");
        bad_line("Q WR 1 44\r");
        sstr("WR 0 3C\n");
        mdl[0] = 8'h3C;
        @(negedge clk);
        chk(regs == mflat(), "R7 recovery after malformed", regs, mflat());
        @(posedge clk); #1;

        // R6 back-pressure on reply
        tx_ready = 1'b0;
        sstr("RD 0\r");
        for (int c = 0; c < 24; c++) begin
            @(posedge clk); #1;
            tx_ready = (c % 3 == 2);
            @(negedge clk);
            if (tx_valid) chk(rx_ready == 1'b0, "R6 rx held during reply", rx_ready, 0);
        end
        @(posedge clk); #1;
        tx_ready = 1'b1;
        wait_reply("R6 reply under back-pressure", mdl[0]);
        chk(rx_ready == 1'b1, "R6 rx ready after reply", rx_ready, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule